// File: doc/BRIEF.md
# Dual-Edge Pulse Capture Timer

This block times one external digital pulse against a free-running counter clocked by the system clock. The input is first resynchronised to the clock and then watched for transitions. Each high-to-low transition copies the counter into a "fall" capture register, and each low-to-high transition copies it into a separate "rise" capture register. Software subtracts the two captures to obtain the low time, the high time and the period of the signal, with wrap-around arithmetic modulo the counter range.

Each capture sets a per-channel pending bit, and the interrupt line is high while either bit is set. A single clear strobe drops both pending bits. A capture register is read through a narrow data port, one half at a time. Reading the low half copies the high half into a holding register, so a later read of the high half matches the same capture even if a new edge has arrived in between. A per-channel overflow flag shows that a capture replaced one whose low half had not been read.

The input must stay high for at least 4 clocks and low for at least 4 clocks, which gives a period of at least 8 clocks. Under these limits every edge is captured exactly once, no more than 4 clocks after the input moves.

Top module: `edge_capture_timer`

## Requirements
- R1: After reset `count_o` is 0. It then rises by one on every clock and wraps modulo 2^CNT_W.
- R2: A high-to-low change of `cap_in` loads the fall capture register on the third rising clock edge after the change. The value loaded is the one `count_o` holds between the second and third of those edges, which is the count at the change plus 2.
- R3: A low-to-high change of `cap_in` loads the rise capture register with the same timing and value rule as R2.
- R4: The capture edge of R2 also sets `irq_src[0]`, and the capture edge of R3 sets `irq_src[1]`. `irq` is high whenever either bit is set. Neither bit is set before its capture edge.
- R5: A one-clock pulse on `irq_clr` clears both bits of `irq_src`. If a capture happens on the same clock, its bit is set anyway.
- R6: `rd_sel` picks the channel (0 = fall, 1 = rise). `rd_hi` picks the half: 0 returns bits [HALF_W-1:0] of the capture register, and 1 returns the held high half. `rd_data` follows these selects combinationally.
- R7: A clock with `rd_stb`=1 and `rd_hi`=0 is a low-half read of the selected channel. It copies that channel's bits [CNT_W-1:HALF_W] into the holding register. High-half reads return this held value until the next low-half read, even after new captures.
- R8: A channel's overflow bit `ovf` is set when a capture on that channel lands while its previous capture has not had its low half read. A low-half read of that channel clears the bit.
- R9: While `cap_in` does not change, both capture registers keep their values.
- R10: After reset, both capture registers, both holding registers, `irq_src`, `irq` and `ovf` are all 0. The reset level of the synchroniser equals the idle input level `IDLE_LVL`, so an input resting at that level produces no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_in | input | 1 | Asynchronous pulse input being timed |
| rd_stb | input | 1 | Read strobe; with rd_hi=0 it performs a low-half read |
| rd_sel | input | 1 | Channel select: 0 fall, 1 rise |
| rd_hi | input | 1 | Half select: 0 low half, 1 held high half |
| rd_data | output | HALF_W | Selected half of the selected capture |
| irq_clr | input | 1 | Strobe that clears both pending bits |
| irq | output | 1 | Interrupt request, OR of the pending bits |
| irq_src | output | 2 | Pending bits: [0] fall, [1] rise |
| ovf | output | 2 | Overflow bits: [0] fall, [1] rise |
| count_o | output | CNT_W | Current value of the free-running counter |

## Verification
The bench builds the block with CNT_W=8, which gives 4-bit halves, with SYNC_STAGES=2 and with IDLE_LVL=1. An 8-bit counter wraps every 256 clocks, so a sweep of every low and high time from 4 to 11 clocks produces many captures on both sides of the wrap. The bench checks each capture against the count it saw when it moved the input, plus 2, and checks each rise-minus-fall difference modulo 256. With 4-bit halves, two captures about 20 clocks apart always differ in the high half, so the bench can see whether a high-half read returns the held value. The same setup lets it make captures with and without a low-half read in between, to set and clear the overflow bits.

// File: rtl/cap_pkg.sv
package cap_pkg;
   localparam int NUM_CH = 2;

   typedef enum logic {
      CH_FALL = 1'b0,
      CH_RISE = 1'b1
   } cap_ch_e;
endpackage

// File: rtl/cap_sync_edge.sv
module cap_sync_edge #(
   parameter int   STAGES   = 2,
   parameter logic IDLE_LVL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise_o,
   output logic fall_o
);
   localparam int TOP = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("cap_sync_edge: STAGES must be at least 2");
   end

   logic [TOP:0] sync_q;
   logic         last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= {STAGES{IDLE_LVL}};
         last_q <= IDLE_LVL;
      end else begin
         sync_q <= {sync_q[TOP-1:0], din};
         last_q <= sync_q[TOP];
      end
   end

   assign rise_o = sync_q[TOP] & ~last_q;
   assign fall_o = ~sync_q[TOP] & last_q;
endmodule

// File: rtl/cap_free_counter.sv
module cap_free_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] cnt_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_o <= '0;
      else        cnt_o <= cnt_o + 1'b1;
   end
endmodule

// File: rtl/cap_channel.sv
module cap_channel #(
   parameter int W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_i,
   input  logic [W-1:0]      cnt_i,
   input  logic              rd_lo_i,
   input  logic              hi_sel_i,
   output logic [W/2-1:0]    data_o,
   output logic [W-1:0]      cap_o,
   output logic              unread_o,
   output logic              ovf_o
);
   localparam int HALF = W / 2;

   logic [W-1:0]    cap_q;
   logic [HALF-1:0] hold_q;
   logic            unread_q;
   logic            ovf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_q    <= '0;
         hold_q   <= '0;
         unread_q <= 1'b0;
         ovf_q    <= 1'b0;
      end else begin
         if (rd_lo_i) begin
            hold_q   <= cap_q[W-1:HALF];
            unread_q <= 1'b0;
            ovf_q    <= 1'b0;
         end
         if (evt_i) begin
            cap_q    <= cnt_i;
            unread_q <= 1'b1;
            if (unread_q && !rd_lo_i) ovf_q <= 1'b1;
         end
      end
   end

   assign data_o   = hi_sel_i ? hold_q : cap_q[HALF-1:0];
   assign cap_o    = cap_q;
   assign unread_o = unread_q;
   assign ovf_o    = ovf_q;
endmodule

// File: rtl/edge_capture_timer.sv
module edge_capture_timer
   import cap_pkg::*;
#(
   parameter int   CNT_W       = 16,
   parameter int   SYNC_STAGES = 2,
   parameter logic IDLE_LVL    = 1'b1,
   localparam int  HALF_W      = CNT_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_in,
   input  logic              rd_stb,
   input  logic              rd_sel,
   input  logic              rd_hi,
   output logic [HALF_W-1:0] rd_data,
   input  logic              irq_clr,
   output logic              irq,
   output logic [1:0]        irq_src,
   output logic [1:0]        ovf,
   output logic [CNT_W-1:0]  count_o
);
   if (CNT_W < 4 || (CNT_W % 2) != 0) begin : g_bad_width
      $error("edge_capture_timer: CNT_W must be even and at least 4");
   end

   logic [NUM_CH-1:0] evt;
   logic [NUM_CH-1:0] rd_lo;
   logic [NUM_CH-1:0] unread;
   logic [HALF_W-1:0] ch_data [NUM_CH];
   logic [CNT_W-1:0]  ch_cap  [NUM_CH];
   logic [CNT_W-1:0]  cap_fall;
   logic [CNT_W-1:0]  cap_rise;
   logic [1:0]        pend_q;

   cap_sync_edge #(.STAGES(SYNC_STAGES), .IDLE_LVL(IDLE_LVL)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .din    (cap_in),
      .rise_o (evt[CH_RISE]),
      .fall_o (evt[CH_FALL])
   );

   cap_free_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .cnt_o (count_o)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      assign rd_lo[i] = rd_stb & ~rd_hi & (rd_sel == 1'(i));
      cap_channel #(.W(CNT_W)) u_ch (
         .clk      (clk),
         .rst_n    (rst_n),
         .evt_i    (evt[i]),
         .cnt_i    (count_o),
         .rd_lo_i  (rd_lo[i]),
         .hi_sel_i (rd_hi),
         .data_o   (ch_data[i]),
         .cap_o    (ch_cap[i]),
         .unread_o (unread[i]),
         .ovf_o    (ovf[i])
      );
   end

   assign cap_fall = ch_cap[CH_FALL];
   assign cap_rise = ch_cap[CH_RISE];
   assign rd_data  = ch_data[rd_sel];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (irq_clr ? 2'b00 : pend_q) | evt;
   end

   assign irq_src = pend_q;
   assign irq     = |pend_q;
endmodule

// File: rtl/edge_capture_timer_chk.sv
module edge_capture_timer_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             irq_clr,
   input logic [1:0]       irq_src,
   input logic [1:0]       ovf,
   input logic [CNT_W-1:0] count_o,
   input logic [1:0]       evt,
   input logic [1:0]       unread,
   input logic [1:0]       rd_lo,
   input logic [CNT_W-1:0] cap_fall,
   input logic [CNT_W-1:0] cap_rise
);
   p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> count_o == CNT_W'($past(count_o) + 1));

   p_fall_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      evt[0] |=> cap_fall == $past(count_o));

   p_rise_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      evt[1] |=> cap_rise == $past(count_o));

   p_fall_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
      evt[0] |=> irq_src[0]);

   p_rise_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
      evt[1] |=> irq_src[1]);

   p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_clr && evt == 2'b00) |=> irq_src == 2'b00);

   p_set_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (evt[0] && unread[0] && !rd_lo[0]) |=> ovf[0]);

   p_clr_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_lo[1] |=> !ovf[1]);

   p_fall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !evt[0] |=> $stable(cap_fall));

   p_rise_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !evt[1] |=> $stable(cap_rise));
endmodule

bind edge_capture_timer edge_capture_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .irq_clr  (irq_clr),
   .irq_src  (irq_src),
   .ovf      (ovf),
   .count_o  (count_o),
   .evt      (evt),
   .unread   (unread),
   .rd_lo    (rd_lo),
   .cap_fall (cap_fall),
   .cap_rise (cap_rise)
);

// File: tb/edge_capture_timer_tb_top.sv
module edge_capture_timer_tb_top;
   localparam int CW = 8;
   localparam int HW = CW / 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cap_in = 1'b1;
   logic          rd_stb = 1'b0;
   logic          rd_sel = 1'b0;
   logic          rd_hi = 1'b0;
   logic [HW-1:0] rd_data;
   logic          irq_clr = 1'b0;
   logic          irq;
   logic [1:0]    irq_src;
   logic [1:0]    ovf;
   logic [CW-1:0] count_o;

   int  checks = 0;
   int  errors = 0;
   bit  done = 1'b0;

   always #10 clk = ~clk;

   edge_capture_timer #(.CNT_W(CW), .SYNC_STAGES(2), .IDLE_LVL(1'b1)) dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_in  (cap_in),
      .rd_stb  (rd_stb),
      .rd_sel  (rd_sel),
      .rd_hi   (rd_hi),
      .rd_data (rd_data),
      .irq_clr (irq_clr),
      .irq     (irq),
      .irq_src (irq_src),
      .ovf     (ovf),
      .count_o (count_o)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   // One-cycle read: low half with strobe, then held high half.
   task automatic read_ch(input logic ch, output logic [CW-1:0] val);
      logic [HW-1:0] lo;
      rd_sel = ch; rd_hi = 1'b0; rd_stb = 1'b1;
      #1 lo = rd_data;
      tick();
      rd_stb = 1'b0; rd_hi = 1'b1;
      #1 val = {rd_data, lo};
      rd_hi = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [CW-1:0] v, exp_fall, exp_rise, got_fall, got_rise, prev;
      logic [HW-1:0] held;
      int prev_lo;
      bit have_rise;

      repeat (3) tick();
      rst_n = 1'b1;
      #1;
      // R10 / R1: reset state
      check("R1 count after reset", count_o, 0);
      check("R10 irq", irq, 0);
      check("R10 irq_src", irq_src, 0);
      check("R10 ovf", ovf, 0);
      rd_sel = 1'b0; rd_hi = 1'b0; #1 check("R10 fall low", rd_data, 0);
      rd_hi = 1'b1; #1 check("R10 fall held high", rd_data, 0);
      rd_sel = 1'b1; rd_hi = 1'b0; #1 check("R10 rise low", rd_data, 0);
      rd_hi = 1'b1; #1 check("R10 rise held high", rd_data, 0);
      rd_hi = 1'b0;

      // R1: increment and wrap over more than one full range
      tick();
      prev = count_o;
      for (int i = 0; i < 300; i++) begin
         tick();
         check("R1 step", count_o, int'(CW'(prev + 1)));
         prev = count_o;
      end
      check("R10 no capture at idle input", irq_src, 0);

      // R2 / R3 / R6: sweep of low and high times
      have_rise = 1'b0;
      prev_lo = 0;
      got_fall = '0;
      exp_rise = '0;
      for (int lo_t = 4; lo_t <= 11; lo_t++) begin
         for (int hi_t = 4; hi_t <= 11; hi_t++) begin
            cap_in = 1'b0;
            v = count_o;
            if (have_rise) begin
               read_ch(1'b1, got_rise);
               check("R3 rise capture", got_rise, exp_rise);
               check("R3 rise minus fall", int'(CW'(got_rise - got_fall)), prev_lo);
               check("R8 no ovf in sweep", ovf, 0);
            end else begin
               tick();
            end
            exp_fall = CW'(v + 2);
            repeat (lo_t - 1) tick();
            cap_in = 1'b1;
            v = count_o;
            read_ch(1'b0, got_fall);
            check("R2 fall capture", got_fall, exp_fall);
            exp_rise = CW'(v + 2);
            prev_lo = lo_t;
            have_rise = 1'b1;
            repeat (hi_t - 1) tick();
         end
      end
      repeat (4) tick();
      check("R4 both pending", irq_src, 3);
      check("R4 irq line", irq, 1);

      // R5: clear
      irq_clr = 1'b1; tick(); irq_clr = 1'b0; #1;
      check("R5 cleared", irq_src, 0);
      check("R5 irq low", irq, 0);

      // R4 / R2: exact capture latency on a falling change
      cap_in = 1'b0;
      v = count_o;
      tick(); tick(); #1;
      check("R4 not yet pending", irq_src[0], 0);
      tick(); #1;
      check("R4 pending on third edge", irq_src[0], 1);
      exp_fall = CW'(v + 2);
      repeat (5) tick();

      // R5: capture on the same clock as clear wins
      cap_in = 1'b1;
      tick(); tick();
      irq_clr = 1'b1; tick(); irq_clr = 1'b0; #1;
      check("R5 rise survives clear", irq_src, 2);
      check("R8 rise overwrite sets ovf", ovf[1], 1);
      repeat (3) tick();
      read_ch(1'b1, v);
      check("R8 ovf cleared by low read", ovf[1], 0);

      // R7: freeze of high half
      rd_sel = 1'b0; rd_hi = 1'b0; rd_stb = 1'b1;
      #1 check("R6 fall low half", rd_data, int'(exp_fall[HW-1:0]));
      tick();
      rd_stb = 1'b0;
      held = exp_fall[CW-1:HW];
      cap_in = 1'b1; repeat (10) tick();
      cap_in = 1'b0; v = count_o; repeat (10) tick();
      exp_fall = CW'(v + 2);
      rd_sel = 1'b0; rd_hi = 1'b1;
      #1 check("R7 held high after new capture", rd_data, int'(held));
      rd_hi = 1'b0;
      #1 check("R7 low half is new", rd_data, int'(exp_fall[HW-1:0]));
      check("R8 no ovf after read", ovf[0], 0);

      // R8: capture over an unread capture
      cap_in = 1'b1; repeat (6) tick();
      cap_in = 1'b0; repeat (6) tick(); #1;
      check("R8 fall ovf set", ovf[0], 1);
      read_ch(1'b0, v);
      check("R8 fall ovf cleared", ovf[0], 0);

      // R9: steady input keeps captures
      read_ch(1'b1, got_rise);
      repeat (30) tick();
      read_ch(1'b1, v);
      check("R9 rise stable", v, got_rise);
      read_ch(1'b0, got_fall);
      repeat (30) tick();
      read_ch(1'b0, v);
      check("R9 fall stable", v, got_fall);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule